// File: doc/BRIEF.md
# Byte-Wide Table CRC Engine

This block folds one message byte per clock into a running CRC. It uses a 256-entry feedback table that is computed at elaboration from the generator polynomial. A parameter picks the register width: 16 bits with generator 0x1021, or 32 bits with generator 0x04C11DB7. The fold is the direct, non-augmented one. The table index is the top CRC byte XORed with the incoming byte. The next value is the old CRC moved up one byte, XORed with the selected entry. The result therefore equals the remainder a bit-serial divider gives with the message fed MSB first, and no zero bytes have to be pushed in before the check bytes go out.

A done strobe takes a snapshot of the CRC. The snapshot is then sent as check bytes, one per clock, most significant byte first, and the final byte carries a last flag. The register starts at zero, and there is no bit reflection and no output inversion.

Top module: `crc_byte_engine`

## Requirements
- R1: After reset, `crc_o` is zero and `chk_valid_o` and `chk_last_o` are low.
- R2: A cycle with `clear_i` high makes `crc_o` zero at the next edge, even when `valid_i` is also high in that cycle.
- R3: In a cycle where both `valid_i` and `clear_i` are low, `crc_o` keeps its value.
- R4: A cycle with `valid_i` high (and `clear_i` low) updates `crc_o` to the value a bitwise divider reaches after shifting in the 8 bits of `data_i`, bit 7 first. For each bit, the divider computes feedback = CRC MSB XOR data bit, shifts the CRC left by one, and XORs in the polynomial (0x1021 at width 16) when the feedback is 1. The initial value is zero, and there is no reflection or final XOR.
- R5: At width 16, the ASCII bytes "123456789" fed from cleared state give `crc_o` = 0x31C3.
- R6: Feeding a message and then its own CRC bytes, high byte first, leaves `crc_o` at zero, with no zero bytes in between.
- R7: The edge that samples `done_i` high starts an emission. On the following CRC_W/8 cycles, `chk_valid_o` is high and `chk_byte_o` shows the snapshot bytes in order, bits [CRC_W-1:CRC_W-8] first. After that, `chk_valid_o` falls.
- R8: `chk_last_o` is high only during the final check byte of an emission.
- R9: A byte accepted in the same cycle as `done_i` is included in the snapshot.
- R10: `done_i` during an emission restarts it from the high byte of a fresh snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Zero the CRC register |
| valid_i | input | 1 | data_i holds a message byte |
| data_i | input | 8 | Message byte |
| done_i | input | 1 | Snapshot the CRC and start check-byte output |
| crc_o | output | CRC_W | Current CRC register |
| chk_byte_o | output | 8 | Check byte being emitted |
| chk_valid_o | output | 1 | chk_byte_o is valid |
| chk_last_o | output | 1 | Final check byte |

## Verification
A wrong table entry or a wrong shift shows up on `crc_o` one cycle after the first byte that indexes it. The bench compares every accepted byte against a bit-serial model, so such an error is seen at once and not only at the end of a message. The residue check with no appended zeros shows whether the fold really is the direct form. If the snapshot or the serializer order is wrong, the wrong check byte appears in the first or second cycle after `done_i`, and the flag checks in each of those cycles catch a last flag out of place.

// File: rtl/crc_byte_pkg.sv
package crc_byte_pkg;

  function automatic logic [31:0] poly_for(int unsigned w);
    return (w == 32) ? 32'h04C1_1DB7 : 32'h0000_1021;
  endfunction

  // Eight direct-form steps on a byte placed at the top of the register
  function automatic logic [31:0] tab_entry(int unsigned idx, int unsigned w,
                                            logic [31:0] poly);
    logic [31:0] r;
    logic [31:0] mask;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    r = (idx & 32'hFF) << (w - 8);
    for (int b = 0; b < 8; b++) begin
      if (r[w-1]) r = ((r << 1) ^ poly) & mask;
      else        r = (r << 1) & mask;
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_byte_table.sv
module crc_byte_table #(
  parameter int unsigned CRC_W = 16
) (
  input  logic [7:0]       idx_i,
  output logic [CRC_W-1:0] entry_o
);
  localparam logic [31:0] POLY = crc_byte_pkg::poly_for(CRC_W);

  logic [CRC_W-1:0] tab [256];

  for (genvar g = 0; g < 256; g++) begin : g_tab
    localparam logic [31:0] ENT = crc_byte_pkg::tab_entry(g, CRC_W, POLY);
    assign tab[g] = ENT[CRC_W-1:0];
  end

  assign entry_o = tab[idx_i];
endmodule

// File: rtl/crc_byte_core.sv
module crc_byte_core #(
  parameter int unsigned CRC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  output logic [CRC_W-1:0] crc_o,
  output logic [CRC_W-1:0] crc_d_o
);
  logic [CRC_W-1:0] crc_q;
  logic [7:0]       idx;
  logic [CRC_W-1:0] entry;

  assign idx = crc_q[CRC_W-1 -: 8] ^ data_i;

  crc_byte_table #(.CRC_W(CRC_W)) u_table (
    .idx_i  (idx),
    .entry_o(entry)
  );

  always_comb begin
    if (clear_i)      crc_d_o = '0;
    else if (valid_i) crc_d_o = {crc_q[CRC_W-9:0], 8'h00} ^ entry;
    else              crc_d_o = crc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '0;
    else         crc_q <= crc_d_o;
  end

  assign crc_o = crc_q;

  assert_clear_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (crc_q == '0));
  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !valid_i) |=> (crc_q == $past(crc_q)));
endmodule

// File: rtl/crc_byte_ser.sv
module crc_byte_ser #(
  parameter int unsigned CRC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [CRC_W-1:0] snap_i,
  output logic [7:0]       byte_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam int unsigned NB  = CRC_W / 8;
  localparam int unsigned CNT_W = $clog2(NB + 1);
  localparam logic [CNT_W-1:0] NB_C = CNT_W'(NB);

  logic [CRC_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (done_i) begin
      sh_q  <= snap_i;
      cnt_q <= NB_C;
    end else if (cnt_q != '0) begin
      sh_q  <= {sh_q[CRC_W-9:0], 8'h00};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign byte_o  = sh_q[CRC_W-1 -: 8];
  assign valid_o = (cnt_q != '0);
  assign last_o  = (cnt_q == CNT_W'(1));

  assert_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (valid_o && !last_o));
  assert_continue_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !done_i) |=> valid_o);
  assert_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !done_i) |=> !valid_o);
  assert_last_in_burst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine #(
  parameter int unsigned CRC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  input  logic             done_i,
  output logic [CRC_W-1:0] crc_o,
  output logic [7:0]       chk_byte_o,
  output logic             chk_valid_o,
  output logic             chk_last_o
);
  logic [CRC_W-1:0] crc_d;

  crc_byte_core #(.CRC_W(CRC_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .valid_i(valid_i),
    .data_i (data_i),
    .crc_o  (crc_o),
    .crc_d_o(crc_d)
  );

  crc_byte_ser #(.CRC_W(CRC_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done_i),
    .snap_i (crc_d),
    .byte_o (chk_byte_o),
    .valid_o(chk_valid_o),
    .last_o (chk_last_o)
  );
endmodule

// File: tb/crc_byte_engine_tb.sv
`timescale 1ns/1ps
module crc_byte_engine_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, valid = 1'b0, done = 1'b0;
  logic [7:0] data = 8'h00;
  logic [W-1:0] crc;
  logic [7:0] cb;
  logic cv, cl;

  int tests = 0, fails = 0;
  logic [W-1:0] model = '0;

  always #4 clk = ~clk;

  crc_byte_engine #(.CRC_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .valid_i(valid),
    .data_i(data), .done_i(done), .crc_o(crc), .chk_byte_o(cb),
    .chk_valid_o(cv), .chk_last_o(cl)
  );

  function automatic logic [W-1:0] bit_step(logic [W-1:0] c, logic [7:0] b);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[W-1] ^ b[i];
      c = c << 1;
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic feed(logic [7:0] b);
    data = b; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    model = bit_step(model, b);
  endtask

  task automatic expect_emit(logic [W-1:0] v);
    chk("R7 hi byte", {24'h0, cb}, {24'h0, v[15:8]});
    chk("R7 valid", {31'h0, cv}, 32'd1);
    chk("R8 not last", {31'h0, cl}, 32'd0);
    @(negedge clk);
    chk("R7 lo byte", {24'h0, cb}, {24'h0, v[7:0]});
    chk("R8 last", {31'h0, cl}, 32'd1);
    @(negedge clk);
    chk("R7 ends", {31'h0, cv}, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] snap;
    logic [7:0] s [9];
    s = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    void'($urandom(32'd2024));
    #3;
    chk("R1 crc", {16'h0, crc}, 32'h0);
    chk("R1 valid", {31'h0, cv}, 32'd0);
    chk("R1 last", {31'h0, cl}, 32'd0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R4/R5 check string
    for (int i = 0; i < 9; i++) begin
      feed(s[i]);
      chk("R4 step", {16'h0, crc}, {16'h0, model});
    end
    chk("R5 check value", {16'h0, crc}, 32'h31C3);

    // R3 idle hold
    repeat (3) @(negedge clk);
    chk("R3 hold", {16'h0, crc}, 32'h31C3);

    // R7/R8 emission
    done = 1'b1; @(negedge clk); done = 1'b0;
    expect_emit(16'h31C3);

    // R6 residue, no zero bytes
    feed(8'h31); feed(8'hC3);
    chk("R6 residue", {16'h0, crc}, 32'h0);

    // R2 clear beats valid
    feed(8'hA5);
    clear = 1'b1; valid = 1'b1; data = 8'h5A; @(negedge clk);
    clear = 1'b0; valid = 1'b0; model = '0;
    chk("R2 clear", {16'h0, crc}, 32'h0);

    // R9 byte with done
    feed(8'h12);
    data = 8'h34; valid = 1'b1; done = 1'b1; @(negedge clk);
    valid = 1'b0; done = 1'b0; model = bit_step(model, 8'h34);
    chk("R9 crc", {16'h0, crc}, {16'h0, model});
    expect_emit(model);

    // R10 restart mid-emission
    done = 1'b1; @(negedge clk);
    snap = model;
    chk("R10 first hi", {24'h0, cb}, {24'h0, snap[15:8]});
    data = 8'h9C; valid = 1'b1; @(negedge clk);
    done = 1'b0; valid = 1'b0; model = bit_step(model, 8'h9C);
    expect_emit(model);

    // random messages with gaps
    for (int m = 0; m < 40; m++) begin
      int len;
      clear = 1'b1; @(negedge clk); clear = 1'b0; model = '0;
      len = 1 + int'($urandom % 24);
      for (int k = 0; k < len; k++) begin
        feed(8'($urandom));
        chk("R4 random", {16'h0, crc}, {16'h0, model});
        if (($urandom % 4) == 0) begin
          @(negedge clk);
          chk("R3 gap", {16'h0, crc}, {16'h0, model});
        end
      end
      snap = model;
      feed(snap[15:8]); feed(snap[7:0]);
      chk("R6 random residue", {16'h0, crc}, 32'h0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule